// File: doc/BRIEF.md
# Port-Based VLAN Egress Filter

This block computes, for one frame at a time, the set of ports a frame may leave on in a nine-port switch whose last port connects to the management CPU. Each ingress port owns a 16-bit membership mask and an 8-bit control byte. A lookup supplies the ingress port number and the frame class. One clock later the block returns the egress port vector. That vector is the ingress port's membership, with the ingress port itself removed, every transmit-blocked port removed, and the CPU port removed unless the CPU allows receive for that class. A port whose receive is blocked forwards nothing.

Software configures the block through a small register bus. A one-bit page select chooses between the control page and the mask page. Writes take effect at the clock edge, and reads are combinational. Port isolation is set up by giving each user port a mask that holds only itself and the CPU port. The CPU port's mask holds every port.

Top module: `pvlan_egress_filter`

## Requirements
- R1: After reset every mask register reads 0x01FF (all nine ports enabled) and every control byte reads 0x00.
- R2: With page select 1, a write at an even offset 2*p (p from 0 to 8) stores all 16 bits of port p's mask. With page select 0, a write at offset p (p from 0 to 8) stores the 8-bit control byte in wdata[7:0]. Any other offset reads 0, and a write there changes no register.
- R3: A lookup presented with lkp_valid high gives egress_valid high on the next cycle. egress_vec is then bits [8:0] of the ingress port's mask, after the filtering in R4 to R7. When egress_valid is low, egress_vec is zero.
- R4: The ingress port is never part of its own egress vector.
- R5: If bit 0 of the ingress port's control byte (receive off) is set, the egress vector is empty.
- R6: A port whose control bit 1 (transmit off) is set never appears in any egress vector.
- R7: Port 8 appears only if the enable bit in port 8's control byte for the frame class is set. Class codes are 0 unicast (enable bit 4), 1 multicast (bit 3) and 2 broadcast (bit 2). Class code 3 never reaches port 8.
- R8: Control bits 2 to 4 on ports 0 to 7 have no effect on forwarding.
- R9: A lookup in the same cycle as a register write is decided with the configuration from before that write.
- R10: A lookup with an ingress port number of 9 or more gives an empty egress vector, with egress_valid still high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_page | input | 1 | Page select: 0 control bytes, 1 masks |
| bus_offs | input | 8 | Register offset within the page |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for the addressed register |
| lkp_valid | input | 1 | Lookup request |
| lkp_port | input | 4 | Ingress port number |
| lkp_class | input | 2 | Frame class code |
| egress_valid | output | 1 | Result valid, one cycle after the request |
| egress_vec | output | 9 | Allowed egress ports, bit n for port n |

## Verification
A register write and a lookup can happen in the same cycle, and the two must not interfere. The bench changes a port's mask and looks up that same port in one cycle. It expects the result to follow the old mask, and it expects the following lookup to follow the new one. Sweeps over every ingress port number (including out-of-range ones) and every class code, under several configurations, are compared against an arithmetic model of the filter rules.

// File: rtl/pvlan_pkg.sv
package pvlan_pkg;
  // frame class codes seen on lkp_class
  typedef enum logic [1:0] {
    CLS_UCAST = 2'd0,
    CLS_MCAST = 2'd1,
    CLS_BCAST = 2'd2,
    CLS_NONE  = 2'd3
  } frame_class_e;

  // control byte bit positions
  localparam int CTL_RX_OFF = 0;
  localparam int CTL_TX_OFF = 1;
  localparam int CTL_BC_EN  = 2;
  localparam int CTL_MC_EN  = 3;
  localparam int CTL_UC_EN  = 4;

  // page select values
  localparam logic PAGE_CTRL = 1'b0;
  localparam logic PAGE_MASK = 1'b1;
endpackage

// File: rtl/pvlan_reg_bank.sv
module pvlan_reg_bank #(
  parameter int               DEPTH   = 9,
  parameter int               WIDTH   = 16,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DEPTH-1:0]             wr_sel,
  input  logic [WIDTH-1:0]             wr_data,
  output logic [DEPTH-1:0][WIDTH-1:0]  q
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic [WIDTH-1:0] r_q;
    logic [WIDTH-1:0] r_d;
    logic             r_en;

    always_comb begin
      r_en = wr_sel[i];
      r_d  = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    r_q <= RST_VAL;
      else if (r_en) r_q <= r_d;
    end

    assign q[i] = r_q;
  end
endmodule

// File: rtl/pvlan_decide.sv
module pvlan_decide
  import pvlan_pkg::*;
#(
  parameter int NUM_PORTS = 9,
  parameter int CPU_PORT  = 8,
  parameter int PORT_W    = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 lkp_valid,
  input  logic [PORT_W-1:0]                    lkp_port,
  input  logic [1:0]                           lkp_class,
  input  logic [NUM_PORTS-1:0][NUM_PORTS-1:0]  fwd_mask,
  input  logic [NUM_PORTS-1:0]                 rx_off,
  input  logic [NUM_PORTS-1:0]                 tx_off,
  input  logic [2:0]                           cpu_cls_en,  // [2] uc, [1] mc, [0] bc
  output logic                                 egress_valid,
  output logic [NUM_PORTS-1:0]                 egress_vec
);
  frame_class_e         cls;
  logic                 hit;
  logic                 sel_rx_off;
  logic [NUM_PORTS-1:0] sel_mask;
  logic [NUM_PORTS-1:0] self_bit;
  logic [NUM_PORTS-1:0] cpu_keep;
  logic                 cpu_ok;
  logic [NUM_PORTS-1:0] vec_d;
  logic                 valid_q;
  logic [NUM_PORTS-1:0] vec_q;

  always_comb begin
    cls        = frame_class_e'(lkp_class);
    hit        = 1'b0;
    sel_rx_off = 1'b0;
    sel_mask   = '0;
    self_bit   = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (int'(lkp_port) == p) begin
        hit         = 1'b1;
        sel_rx_off  = rx_off[p];
        sel_mask    = fwd_mask[p];
        self_bit[p] = 1'b1;
      end
    end
    case (cls)
      CLS_UCAST: cpu_ok = cpu_cls_en[2];
      CLS_MCAST: cpu_ok = cpu_cls_en[1];
      CLS_BCAST: cpu_ok = cpu_cls_en[0];
      default:   cpu_ok = 1'b0;
    endcase
    cpu_keep           = '1;
    cpu_keep[CPU_PORT] = cpu_ok;
    if (hit && !sel_rx_off) vec_d = sel_mask & ~tx_off & ~self_bit & cpu_keep;
    else                    vec_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
    end else begin
      valid_q <= lkp_valid;
      vec_q   <= lkp_valid ? vec_d : '0;
    end
  end

  assign egress_valid = valid_q;
  assign egress_vec   = vec_q;
endmodule

// File: rtl/pvlan_egress_filter.sv
module pvlan_egress_filter
  import pvlan_pkg::*;
#(
  parameter int NUM_PORTS = 9,
  parameter int CPU_PORT  = NUM_PORTS - 1,
  parameter int MASK_W    = 16,
  parameter int CTRL_W    = 8,
  parameter int OFFS_W    = 8,
  parameter int PORT_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic                 bus_page,
  input  logic [OFFS_W-1:0]    bus_offs,
  input  logic [MASK_W-1:0]    bus_wdata,
  output logic [MASK_W-1:0]    bus_rdata,
  input  logic                 lkp_valid,
  input  logic [PORT_W-1:0]    lkp_port,
  input  logic [1:0]           lkp_class,
  output logic                 egress_valid,
  output logic [NUM_PORTS-1:0] egress_vec
);
  localparam logic [MASK_W-1:0] MASK_RST = MASK_W'({NUM_PORTS{1'b1}});
  localparam logic [CTRL_W-1:0] CTRL_RST = '0;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NUM_PORTS-1:0]                mask_sel;
  logic [NUM_PORTS-1:0]                ctrl_sel;
  logic [NUM_PORTS-1:0][MASK_W-1:0]    mask_q;
  logic [NUM_PORTS-1:0][CTRL_W-1:0]    ctrl_q;
  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] fwd_mask;
  logic [NUM_PORTS-1:0]                rx_off;
  logic [NUM_PORTS-1:0]                tx_off;
  logic [2:0]                          cpu_cls_en;

  // address decode and read mux
  always_comb begin
    mask_sel  = '0;
    ctrl_sel  = '0;
    bus_rdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (bus_page == PAGE_MASK && int'(bus_offs) == 2 * p) begin
        mask_sel[p] = bus_we;
        bus_rdata   = mask_q[p];
      end
      if (bus_page == PAGE_CTRL && int'(bus_offs) == p) begin
        ctrl_sel[p] = bus_we;
        bus_rdata   = MASK_W'(ctrl_q[p]);
      end
    end
  end

  pvlan_reg_bank #(.DEPTH(NUM_PORTS), .WIDTH(MASK_W), .RST_VAL(MASK_RST)) u_masks (
    .clk(clk), .rst_n(rst_sync_n), .wr_sel(mask_sel), .wr_data(bus_wdata), .q(mask_q)
  );

  pvlan_reg_bank #(.DEPTH(NUM_PORTS), .WIDTH(CTRL_W), .RST_VAL(CTRL_RST)) u_ctrls (
    .clk(clk), .rst_n(rst_sync_n), .wr_sel(ctrl_sel), .wr_data(bus_wdata[CTRL_W-1:0]), .q(ctrl_q)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_split
    assign fwd_mask[p] = mask_q[p][NUM_PORTS-1:0];
    assign rx_off[p]   = ctrl_q[p][CTL_RX_OFF];
    assign tx_off[p]   = ctrl_q[p][CTL_TX_OFF];
  end
  assign cpu_cls_en = {ctrl_q[CPU_PORT][CTL_UC_EN], ctrl_q[CPU_PORT][CTL_MC_EN],
                       ctrl_q[CPU_PORT][CTL_BC_EN]};

  pvlan_decide #(.NUM_PORTS(NUM_PORTS), .CPU_PORT(CPU_PORT), .PORT_W(PORT_W)) u_decide (
    .clk(clk), .rst_n(rst_sync_n), .lkp_valid(lkp_valid), .lkp_port(lkp_port),
    .lkp_class(lkp_class), .fwd_mask(fwd_mask), .rx_off(rx_off), .tx_off(tx_off),
    .cpu_cls_en(cpu_cls_en), .egress_valid(egress_valid), .egress_vec(egress_vec)
  );
endmodule

// File: rtl/pvlan_egress_filter_chk.sv
module pvlan_egress_filter_chk #(
  parameter int NUM_PORTS = 9,
  parameter int CPU_PORT  = 8,
  parameter int PORT_W    = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 lkp_valid,
  input logic [PORT_W-1:0]    lkp_port,
  input logic [1:0]           lkp_class,
  input logic [NUM_PORTS-1:0] rx_off,
  input logic [NUM_PORTS-1:0] tx_off,
  input logic [2:0]           cpu_cls_en,
  input logic                 egress_valid,
  input logic [NUM_PORTS-1:0] egress_vec
);
  logic [NUM_PORTS-1:0] now_self;
  logic                 now_range;
  logic                 now_rx_block;
  logic                 now_cpu_ok;
  logic [NUM_PORTS-1:0] last_self;
  logic [NUM_PORTS-1:0] last_tx;
  logic                 last_rx_block;
  logic                 last_cpu_ok;

  always_comb begin
    now_self     = '0;
    now_range    = 1'b0;
    now_rx_block = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (int'(lkp_port) == p) begin
        now_self[p]  = 1'b1;
        now_range    = 1'b1;
        now_rx_block = rx_off[p];
      end
    end
    now_cpu_ok = (lkp_class == 2'd0 && cpu_cls_en[2]) ||
                 (lkp_class == 2'd1 && cpu_cls_en[1]) ||
                 (lkp_class == 2'd2 && cpu_cls_en[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_self     <= '0;
      last_tx       <= '0;
      last_rx_block <= 1'b0;
      last_cpu_ok   <= 1'b1;
    end else if (lkp_valid) begin
      last_self     <= now_self;
      last_tx       <= tx_off;
      last_rx_block <= now_rx_block;
      last_cpu_ok   <= now_cpu_ok;
    end
  end

  p_valid_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid |=> egress_valid);
  p_idle_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !egress_valid |-> (egress_vec == '0));
  p_no_self_r4: assert property (@(posedge clk) disable iff (!rst_n)
    egress_valid |-> ((egress_vec & last_self) == '0));
  p_rx_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (egress_valid && last_rx_block) |-> (egress_vec == '0));
  p_tx_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    egress_valid |-> ((egress_vec & last_tx) == '0));
  p_cpu_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (egress_valid && !last_cpu_ok) |-> !egress_vec[CPU_PORT]);
  p_out_of_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && !now_range) |=> (egress_vec == '0));
endmodule

bind pvlan_egress_filter pvlan_egress_filter_chk #(
  .NUM_PORTS(NUM_PORTS), .CPU_PORT(CPU_PORT), .PORT_W(PORT_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .lkp_valid(lkp_valid), .lkp_port(lkp_port),
  .lkp_class(lkp_class), .rx_off(rx_off), .tx_off(tx_off), .cpu_cls_en(cpu_cls_en),
  .egress_valid(egress_valid), .egress_vec(egress_vec)
);

// File: tb/pvlan_egress_filter_tb.sv
module pvlan_egress_filter_tb;
  localparam int NP  = 9;
  localparam int CPU = 8;

  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic        bus_page;
  logic [7:0]  bus_offs;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        lkp_valid;
  logic [3:0]  lkp_port;
  logic [1:0]  lkp_class;
  logic        egress_valid;
  logic [8:0]  egress_vec;

  int n_checks;
  int n_fail;
  bit done;

  logic [15:0] m_mask [NP];
  logic [7:0]  m_ctrl [NP];

  pvlan_egress_filter u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_page(bus_page), .bus_offs(bus_offs),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lkp_valid(lkp_valid), .lkp_port(lkp_port),
    .lkp_class(lkp_class), .egress_valid(egress_valid), .egress_vec(egress_vec)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] model(input int port, input int cls);
    logic [8:0] v;
    logic       ok;
    if (port >= NP) return 9'd0;
    if (m_ctrl[port][0]) return 9'd0;
    v = m_mask[port][8:0];
    v[port] = 1'b0;
    for (int q = 0; q < NP; q++) if (m_ctrl[q][1]) v[q] = 1'b0;
    case (cls)
      0: ok = m_ctrl[CPU][4];
      1: ok = m_ctrl[CPU][3];
      2: ok = m_ctrl[CPU][2];
      default: ok = 1'b0;
    endcase
    if (!ok) v[CPU] = 1'b0;
    return v;
  endfunction

  task automatic wr(input logic page, input int offs, input logic [15:0] data);
    @(negedge clk);
    bus_we = 1'b1; bus_page = page; bus_offs = 8'(offs); bus_wdata = data;
    @(negedge clk);
    bus_we = 1'b0;
    if (page && offs % 2 == 0 && offs / 2 < NP) m_mask[offs/2] = data;
    if (!page && offs < NP) m_ctrl[offs] = data[7:0];
  endtask

  task automatic rd_check(input logic page, input int offs, input logic [15:0] exp, input string req);
    @(negedge clk);
    bus_page = page; bus_offs = 8'(offs);
    #1;
    check(bus_rdata == exp, req, bus_rdata, exp);
  endtask

  task automatic lookup(input int port, input int cls, input string req);
    logic [8:0] exp;
    exp = model(port, cls);
    @(negedge clk);
    lkp_valid = 1'b1; lkp_port = 4'(port); lkp_class = 2'(cls);
    @(negedge clk);
    lkp_valid = 1'b0;
    #1;
    check(egress_valid == 1'b1, "R3 valid", 16'(egress_valid), 16'd1);
    check(egress_vec == exp, req, 16'(egress_vec), 16'(exp));
  endtask

  task automatic sweep(input string req);
    for (int p = 0; p < 16; p++)
      for (int c = 0; c < 4; c++) lookup(p, c, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; bus_we = 1'b0; bus_page = 1'b0; bus_offs = '0; bus_wdata = '0;
    lkp_valid = 1'b0; lkp_port = '0; lkp_class = '0;
    for (int p = 0; p < NP; p++) begin m_mask[p] = 16'h01FF; m_ctrl[p] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    #1;
    check(egress_valid == 1'b0, "R1 valid idle", 16'(egress_valid), 16'd0);
    for (int p = 0; p < NP; p++) begin
      rd_check(1'b1, 2 * p, 16'h01FF, "R1 mask reset");
      rd_check(1'b0, p, 16'h0000, "R1 ctrl reset");
    end

    // R3 R4 R7 R10: reset configuration, all ports and classes
    sweep("R4 R7 R10 reset config");

    // R3: isolation setup, CPU accepts every class
    for (int p = 0; p < CPU; p++) wr(1'b1, 2 * p, 16'((1 << p) | (1 << CPU)));
    wr(1'b0, CPU, 16'h001C);
    sweep("R3 isolation");

    // R7: each combination of CPU class enables
    for (int e = 0; e < 8; e++) begin
      wr(1'b0, CPU, 16'(e << 2));
      for (int c = 0; c < 4; c++) begin
        lookup(3, c, "R7 cpu class gate");
        lookup(CPU, c, "R7 cpu self");
      end
    end

    // R6 R8: full masks, tx off on port 5, class bits on user port 2
    for (int p = 0; p < NP; p++) wr(1'b1, 2 * p, 16'h01FF);
    wr(1'b0, CPU, 16'h0000);
    wr(1'b0, 5, 16'h0002);
    wr(1'b0, 2, 16'h001C);
    sweep("R6 R8 tx off and user class bits");

    // R5: rx off on port 4
    wr(1'b0, 4, 16'h0001);
    wr(1'b0, CPU, 16'h0014);
    sweep("R5 rx off");
    lookup(4, 0, "R5 rx off ingress empty");

    // R2: unmapped offsets, full-width storage, empty mask
    wr(1'b1, 3, 16'hFFFF);
    wr(1'b1, 18, 16'hFFFF);
    wr(1'b1, 64, 16'hFFFF);
    wr(1'b0, 9, 16'h00FF);
    wr(1'b0, 32, 16'h00FF);
    rd_check(1'b1, 3, 16'h0000, "R2 odd offset");
    rd_check(1'b1, 18, 16'h0000, "R2 mask beyond range");
    rd_check(1'b0, 9, 16'h0000, "R2 ctrl beyond range");
    for (int p = 0; p < NP; p++) begin
      rd_check(1'b1, 2 * p, m_mask[p], "R2 mask unchanged");
      rd_check(1'b0, p, 16'(m_ctrl[p]), "R2 ctrl unchanged");
    end
    wr(1'b1, 12, 16'hA5C3);
    rd_check(1'b1, 12, 16'hA5C3, "R2 full width mask");
    wr(1'b0, 7, 16'h12E0);
    rd_check(1'b0, 7, 16'h00E0, "R2 ctrl byte");
    sweep("R3 high mask bits");
    wr(1'b1, 2, 16'h0000);
    lookup(1, 2, "R3 empty mask");

    // R9: write and lookup in the same cycle
    wr(1'b1, 2, 16'h01FF);
    begin
      logic [8:0] exp_old;
      logic [8:0] exp_new;
      exp_old = model(1, 2);
      @(negedge clk);
      bus_we = 1'b1; bus_page = 1'b1; bus_offs = 8'd2; bus_wdata = 16'h0004;
      lkp_valid = 1'b1; lkp_port = 4'd1; lkp_class = 2'd2;
      @(negedge clk);
      bus_we = 1'b0; lkp_valid = 1'b0;
      m_mask[1] = 16'h0004;
      #1;
      check(egress_vec == exp_old, "R9 old config", 16'(egress_vec), 16'(exp_old));
      exp_new = model(1, 2);
      lookup(1, 2, "R9 new config");
      check(exp_new == 9'h004, "R9 model", 16'(exp_new), 16'h0004);
    end

    // R3: output clears when idle
    @(negedge clk);
    #1;
    check(egress_valid == 1'b0 && egress_vec == '0, "R3 idle", 16'(egress_vec), 16'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule